// File: doc/BRIEF.md
# SPI command frame receiver

This block takes command frames for an eight-channel DAC controller from a three-wire serial link. The link has an active-low select line, a serial clock and a data line. All three are brought into the system clock domain through synchronizer flops, and edges are found there. While select is low, each rising serial clock edge shifts one data bit into a frame register. When select returns high, the block decodes the last 24 bits received into a 4-bit command, a 4-bit channel address and a 16-bit data word. It then raises a single-cycle execute strobe.

A host may send either the minimal 24-bit frame or a 32-bit frame that begins with eight filler bits. Only the final 24 bits count. A frame that ends with fewer than 24 bits produces an error pulse instead of an execute strobe. The decoded fields stay on the outputs until the next good frame. The DAC code is the left-justified top part of the data word, and its width is a parameter. The system clock must run at least four times faster than the serial clock.

Top module: `spi_frame_rx`

## Requirements
- R1: After reset, `execStb` and `shortErr` are low and `cmdOut`, `addrOut`, `dataOut` and `dacCode` are all zero.
- R2: A 24-bit frame is decoded with its first 4 bits (MSB first) on `cmdOut`, the next 4 bits on `addrOut` and the last 16 bits on `dataOut`. `execStb` follows within 8 system cycles of select rising.
- R3: In a frame longer than 24 bits (32 or 40 bits), only the last 24 bits received are decoded. The leading bits have no effect on any output.
- R4: A frame of fewer than 24 bits, including one with no clock edges at all, gives exactly one `shortErr` pulse and no `execStb`. All field outputs stay unchanged.
- R5: `execStb` is high for exactly one system-clock cycle, once per valid frame, and is never high in the same cycle as `shortErr`.
- R6: `cmdOut`, `addrOut`, `dataOut` and `dacCode` change only in the cycle in which `execStb` is raised, and hold their values otherwise.
- R7: Serial clock edges while select is high are ignored. They produce no strobe, no error pulse and no change on any output.
- R8: The serial clock level when select falls does not matter. The first data bit is the one present at the first rising clock edge after select falls.
- R9: `dacCode` equals the top `CODE_W` bits of the decoded data word. For the default `CODE_W` of 12 this is data bits 15..4, and the lower 4 bits are don't-care.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiCsN | input | 1 | Serial select, active low; its rising edge ends a frame |
| spiSck | input | 1 | Serial clock, data sampled on rising edges |
| spiSdi | input | 1 | Serial data in, MSB first |
| execStb | output | 1 | One-cycle strobe: a complete frame was decoded |
| shortErr | output | 1 | One-cycle pulse: frame ended with fewer than 24 bits |
| cmdOut | output | CMD_W (4) | Decoded command field |
| addrOut | output | ADDR_W (4) | Decoded channel address field |
| dataOut | output | FRAME_BITS-CMD_W-ADDR_W (16) | Decoded data word |
| dacCode | output | CODE_W (12) | Left-justified DAC code taken from the data word |

## Verification
The in-line assertions check several properties on every cycle:
- the execute strobe lasts one cycle and never coincides with the error pulse;
- an execute or error pulse follows only a frame whose bit count was at least, or less than, 24;
- the bit counter stays still while select is high;
- the field outputs hold steady outside a load.

Only the bench scenarios can show that the decoded fields carry the right bits in the right order. The same is true for discarding the leading bits of 32- and 40-bit frames, for the first-bit alignment when select falls with the clock high, and for the short-frame and idle-clock cases leaving the outputs untouched.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  // strobes handed from the frame control to the datapath
  typedef struct packed {
    logic shiftEn;  // take one serial bit into the frame register
    logic loadOut;  // copy the frame register onto the held outputs
  } frameStb_t;
endpackage

// File: rtl/spi_frame_sync.sv
module spi_frame_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stageQ[0] <= RESET_VAL;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stageQ[s] <= RESET_VAL;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int FRAME_BITS = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csSync,
  input  logic      sckSync,
  output frameStb_t strb,
  output logic      execStb,
  output logic      shortErr
);
  localparam int CNT_W = $clog2(FRAME_BITS) + 2;
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BITS);

  logic             csPrev, sckPrev;
  logic             csRise, csFall, sckRise, frameOk;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    csRise       = csSync & ~csPrev;
    csFall       = ~csSync & csPrev;
    sckRise      = sckSync & ~sckPrev & ~csSync;
    frameOk      = bitCnt >= FRAME_CNT;
    strb.shiftEn = sckRise;
    strb.loadOut = csRise & frameOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sckPrev  <= 1'b0;
      bitCnt   <= '0;
      execStb  <= 1'b0;
      shortErr <= 1'b0;
    end else begin
      csPrev   <= csSync;
      sckPrev  <= sckSync;
      execStb  <= csRise & frameOk;
      shortErr <= csRise & ~frameOk;
      if (csFall)                          bitCnt <= '0;
      else if (sckRise && bitCnt != '1)    bitCnt <= bitCnt + 1'b1;
    end
  end

  AST_EXEC_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    execStb |=> !execStb); // R5
  AST_EXEC_NOT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    !(execStb && shortErr)); // R5
  AST_EXEC_FULL_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    execStb |-> $past(bitCnt) >= FRAME_CNT); // R2
  AST_SHORT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    shortErr |-> $past(bitCnt) < FRAME_CNT); // R4
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (csSync && $past(csSync)) |-> $stable(bitCnt)); // R7
endmodule

// File: rtl/spi_frame_dpath.sv
module spi_frame_dpath
  import spi_frame_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int CMD_W = 4,
  parameter int ADDR_W = 4,
  parameter int CODE_W = 12
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               sdiSync,
  input  frameStb_t                          strb,
  output logic [CMD_W-1:0]                   cmdOut,
  output logic [ADDR_W-1:0]                  addrOut,
  output logic [FRAME_BITS-CMD_W-ADDR_W-1:0] dataOut,
  output logic [CODE_W-1:0]                  dacCode
);
  localparam int DATA_W = FRAME_BITS - CMD_W - ADDR_W;

  logic [FRAME_BITS-1:0] frameQ;
  logic [CMD_W-1:0]      cmdQ;
  logic [ADDR_W-1:0]     addrQ;
  logic [DATA_W-1:0]     dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ <= '0;
      cmdQ   <= '0;
      addrQ  <= '0;
      dataQ  <= '0;
    end else begin
      if (strb.shiftEn) frameQ <= {frameQ[FRAME_BITS-2:0], sdiSync};
      if (strb.loadOut) begin
        cmdQ  <= frameQ[FRAME_BITS-1 -: CMD_W];
        addrQ <= frameQ[DATA_W+ADDR_W-1 -: ADDR_W];
        dataQ <= frameQ[DATA_W-1:0];
      end
    end
  end

  assign cmdOut  = cmdQ;
  assign addrOut = addrQ;
  assign dataOut = dataQ;
  assign dacCode = dataQ[DATA_W-1 -: CODE_W];

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadOut |=> ($stable(cmdQ) && $stable(addrQ) && $stable(dataQ))); // R6
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_frame_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int CMD_W = 4,
  parameter int ADDR_W = 4,
  parameter int CODE_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               spiCsN,
  input  logic                               spiSck,
  input  logic                               spiSdi,
  output logic                               execStb,
  output logic                               shortErr,
  output logic [CMD_W-1:0]                   cmdOut,
  output logic [ADDR_W-1:0]                  addrOut,
  output logic [FRAME_BITS-CMD_W-ADDR_W-1:0] dataOut,
  output logic [CODE_W-1:0]                  dacCode
);
  logic [2:0] lineSync;
  frameStb_t  strb;

  spi_frame_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({spiCsN, spiSck, spiSdi}),
    .syncOut(lineSync)
  );

  spi_frame_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .csSync(lineSync[2]), .sckSync(lineSync[1]),
    .strb(strb), .execStb(execStb), .shortErr(shortErr)
  );

  spi_frame_dpath #(.FRAME_BITS(FRAME_BITS), .CMD_W(CMD_W), .ADDR_W(ADDR_W),
                    .CODE_W(CODE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .sdiSync(lineSync[0]), .strb(strb),
    .cmdOut(cmdOut), .addrOut(addrOut), .dataOut(dataOut), .dacCode(dacCode)
  );
endmodule

// File: tb/spi_frame_rx_test.sv
module spi_frame_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int NVEC = 6;
  // [45:40] bit count, [39:0] frame bits right-aligned, sent MSB first
  localparam logic [45:0] VEC [NVEC] = '{
    {6'd24, 40'h000031ABC5},
    {6'd24, 40'h0000F7FFFF},
    {6'd32, 40'h00A5020F0F},
    {6'd32, 40'h00FF6F8001},
    {6'd40, 40'h1234455AA5},
    {6'd24, 40'h0000000000}
  };

  logic clk = 0, rstN = 0, spiCsN = 1, spiSck = 0, spiSdi = 0;
  logic execStb, shortErr;
  logic [3:0] cmdOut, addrOut;
  logic [15:0] dataOut;
  logic [11:0] dacCode;

  int total = 0, bad = 0;
  int execCnt = 0, shortCnt = 0, widthBad = 0;
  logic execPrev = 0;

  spi_frame_rx uut (.clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck),
    .spiSdi(spiSdi), .execStb(execStb), .shortErr(shortErr), .cmdOut(cmdOut),
    .addrOut(addrOut), .dataOut(dataOut), .dacCode(dacCode));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (execStb) execCnt++;
    if (shortErr) shortCnt++;
    if (execStb && execPrev) widthBad++;
    execPrev = execStb;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [39:0] bits, input int n, input bit startHigh);
    spiSck = startHigh;
    waitClk(HALF);
    spiCsN = 0;
    waitClk(HALF);
    if (startHigh) begin
      spiSck = 0;
      waitClk(HALF);
    end
    for (int b = n - 1; b >= 0; b--) begin
      spiSdi = bits[b];
      spiSck = 0;
      waitClk(HALF);
      spiSck = 1;
      waitClk(HALF);
    end
    spiSck = 0;
    waitClk(HALF);
    spiCsN = 1;
    waitClk(10);
  endtask

  task automatic expectFrame(input string req, input logic [23:0] f,
                             input int e0, input int s0);
    check({req, " exec count"}, 32'(execCnt), 32'(e0 + 1));
    check({req, " short count"}, 32'(shortCnt), 32'(s0));
    check({req, " cmd"}, {28'd0, cmdOut}, {28'd0, f[23:20]});
    check({req, " addr"}, {28'd0, addrOut}, {28'd0, f[19:16]});
    check({req, " data"}, {16'd0, dataOut}, {16'd0, f[15:0]});
    check({req, " R9 dac code"}, {20'd0, dacCode}, {20'd0, f[15:4]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0, s0;
    logic [35:0] held;
    waitClk(5);
    // R1: reset state
    check("R1 execStb", {31'd0, execStb}, 32'd0);
    check("R1 shortErr", {31'd0, shortErr}, 32'd0);
    check("R1 outputs", {cmdOut, addrOut, dataOut, dacCode[3:0]}, 32'd0);
    rstN = 1;
    waitClk(5);

    // R2 / R3 / R9: vector table
    for (int i = 0; i < NVEC; i++) begin
      e0 = execCnt; s0 = shortCnt;
      sendFrame(VEC[i][39:0], int'(VEC[i][45:40]), 1'b0);
      expectFrame(VEC[i][45:40] == 6'd24 ? "R2" : "R3", VEC[i][23:0], e0, s0);
    end

    // load a known value before the negative cases
    e0 = execCnt; s0 = shortCnt;
    sendFrame(40'h00002C1234, 24, 1'b0);
    expectFrame("R2", 24'h2C1234, e0, s0);
    held = {cmdOut, addrOut, dataOut, dacCode};

    // R4: 23-bit frame
    e0 = execCnt; s0 = shortCnt;
    sendFrame(40'h00007FFFFF, 23, 1'b0);
    check("R4 23-bit no exec", 32'(execCnt), 32'(e0));
    check("R4 23-bit one error", 32'(shortCnt), 32'(s0 + 1));
    check("R4 23-bit outputs held", {28'd0, held[35:32]}, {28'd0, cmdOut});
    check("R4 23-bit data held", held[31:0], {addrOut, dataOut, dacCode});

    // R4: select pulse with no clocks
    e0 = execCnt; s0 = shortCnt;
    sendFrame(40'h0, 0, 1'b0);
    check("R4 empty no exec", 32'(execCnt), 32'(e0));
    check("R4 empty one error", 32'(shortCnt), 32'(s0 + 1));
    check("R4 empty outputs held", held[31:0], {addrOut, dataOut, dacCode});

    // R7: clock activity with select high
    e0 = execCnt; s0 = shortCnt;
    for (int k = 0; k < 30; k++) begin
      spiSdi = k[0];
      spiSck = 1; waitClk(HALF);
      spiSck = 0; waitClk(HALF);
    end
    waitClk(10);
    check("R7 no exec", 32'(execCnt), 32'(e0));
    check("R7 no error", 32'(shortCnt), 32'(s0));
    check("R7 outputs held", held[31:0], {addrOut, dataOut, dacCode});
    check("R7 cmd held", {28'd0, cmdOut}, {28'd0, held[35:32]});

    // R8: clock high when select falls
    e0 = execCnt; s0 = shortCnt;
    sendFrame(40'h0000936E5D, 24, 1'b1);
    expectFrame("R8", 24'h936E5D, e0, s0);

    // R5: every strobe was one cycle wide
    check("R5 strobe width", 32'(widthBad), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule